// File: doc/BRIEF.md
# Shadowed PWM Compare-Match Unit

This block watches the counter of a PWM time-base and raises a one-clock event whenever that counter reaches a programmed compare value. It holds two compare channels, A and B, that act independently of each other. Each event comes out together with a flag that gives the count direction at the moment of the match. Downstream action logic can then treat a match on the rising slope apart from a match on the falling slope.

Each channel can be programmed directly or through a shadow stage. In direct mode a bus write changes the value used for matching at the next clock edge. In shadow mode the write lands in a holding copy. That copy moves into the working register only on a selected time-base event: counter at zero, counter at period, either one, or never. A pending flag per channel shows that the shadow holds a value not yet transferred. The time-base marks each fresh counter value with a strobe, so a counter that stalls under a prescaler produces no repeated events.

Top module: `pwm_cmp_unit`

## Requirements
- R1: After reset the control register reads 0 (shadow mode, load on zero, no pending values), both compare values read 0, and no event output is high.
- R2: Bus map: address 0 is control, address 1 is compare A, address 2 is compare B. Control bits [1:0] and [3:2] are the load selectors of A and B. Bits 4 and 6 select direct mode (1) or shadow mode (0) for A and B. Bits 8 and 9 are the read-only pending flags of A and B, and all other bits read 0. A compare address reads the shadow copy in shadow mode and the working copy in direct mode.
- R3: When `cnt_new` is high and `cnt` equals a channel's working value, that channel's event output is high during the following cycle only, and its up flag then equals the `cnt_up` of the matching cycle. The up flag is low whenever the event is low.
- R4: A cycle with `cnt_new` low produces no event, so a counter that holds one value for several cycles yields a single event.
- R5: In up-down counting, a compare value strictly between 0 and the period gives one event with up flag 1 and one with up flag 0 in each period. A value of 0 or of the period gives exactly one event per period.
- R6: In direct mode a compare write changes the working value at the next edge. A match test in the same cycle as the write still uses the old value.
- R7: In shadow mode a compare write leaves the working value unchanged. The shadow is copied to the working value on a cycle with `zero_evt` (selector 00), `prd_evt` (01), or either one (10). Selector 11 never copies.
- R8: The pending flag sets on a shadow write and clears on a transfer. If a write and a transfer fall in the same cycle, the old shadow moves to the working value, the new data stays in the shadow, and the flag stays set.
- R9: Channels A and B have separate values, modes and selectors, and neither channel's writes or events affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt | input | CNT_W | Time-base counter value |
| cnt_new | input | 1 | High when `cnt` carries a freshly advanced value |
| cnt_up | input | 1 | Count direction, 1 = counting up |
| zero_evt | input | 1 | Strobe: counter equals zero |
| prd_evt | input | 1 | Strobe: counter equals period |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Register write data |
| bus_rdata | output | CNT_W | Register read data (combinational on address) |
| cmpa_evt | output | 1 | Channel A match pulse |
| cmpa_up | output | 1 | Direction flag of channel A pulse |
| cmpb_evt | output | 1 | Channel B match pulse |
| cmpb_up | output | 1 | Direction flag of channel B pulse |

## Verification
Two functions can fall in the same cycle here: a shadow transfer and a software write to the same shadow, and a match test and a change of the working value. The bench provokes the first by writing compare A in the very cycle that carries the zero strobe. It judges the result through later match timing (the old shadow value must match) and through the pending flag read at address 0. It provokes the second by writing a direct-mode compare while the counter sits at the new value, then checks that no event appears for that cycle and that the next fresh visit to that value does fire.

// File: rtl/pwm_cmp_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the compare-match unit.
// Assumes the data width is at least 10 bits so the control word fits.
package pwm_cmp_pkg;
    localparam int NCH      = 2;   // compare channels A and B
    localparam int ADDR_W   = 2;
    localparam int CTRL_ADR = 0;
    localparam int CMP_BASE = 1;   // A at CMP_BASE, B at CMP_BASE+1
    localparam int LD_LSB   = 0;   // selector of channel i at LD_LSB+2*i
    localparam int DIR_LSB  = 4;   // direct bit of channel i at DIR_LSB+2*i
    localparam int PEND_LSB = 8;   // pending flag of channel i at PEND_LSB+i

    typedef enum logic [1:0] {
        LD_ON_ZERO = 2'b00,
        LD_ON_PRD  = 2'b01,
        LD_ON_BOTH = 2'b10,
        LD_FROZEN  = 2'b11
    } ld_sel_e;
endpackage

// File: rtl/pwm_cmp_ctrl.sv
`timescale 1ns/1ps
// Control register and read-back multiplexer.
// Holds per-channel load selector and direct-mode bit; assembles the
// read word from control state, pending flags and the selected copy.
// Assumes CNT_W >= PEND_LSB + NCH.
module pwm_cmp_ctrl
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [1:0]        new_ld  [NCH],
    input  logic              new_dir [NCH],
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  act     [NCH],
    input  logic [CNT_W-1:0]  shd     [NCH],
    input  logic              pend    [NCH],
    output ld_sel_e           ld_sel  [NCH],
    output logic              direct  [NCH],
    output logic [CNT_W-1:0]  rdata
);
    // Control state update on a write to the control address.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) begin
                ld_sel[i] <= LD_ON_ZERO;
                direct[i] <= 1'b0;
            end else if (ctrl_wr) begin
                ld_sel[i] <= ld_sel_e'(new_ld[i]);
                direct[i] <= new_dir[i];
            end
        end
    end

    // Read multiplexer: control word or the visible copy of a compare.
    always_comb begin
        rdata = '0;
        if (rd_addr == ADDR_W'(CTRL_ADR)) begin
            for (int i = 0; i < NCH; i++) begin
                rdata[LD_LSB + 2*i +: 2] = ld_sel[i];
                rdata[DIR_LSB + 2*i]     = direct[i];
                rdata[PEND_LSB + i]      = pend[i];
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (rd_addr == ADDR_W'(CMP_BASE + i))
                    rdata = direct[i] ? act[i] : shd[i];
            end
        end
    end
endmodule

// File: rtl/pwm_cmp_chan.sv
`timescale 1ns/1ps
// One compare channel: shadow/working register pair, load-event
// selection and registered match detection with direction tag.
// Assumes zero_evt/prd_evt are single-cycle strobes from the time-base.
module pwm_cmp_chan
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             direct,
    input  ld_sel_e          ld_sel,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_new,
    input  logic             cnt_up,
    input  logic             zero_evt,
    input  logic             prd_evt,
    output logic [CNT_W-1:0] act,
    output logic [CNT_W-1:0] shd,
    output logic             pend,
    output logic             evt,
    output logic             evt_up
);
    logic load_hit;
    logic hit;

    // Decode whether the selected transfer event happens this cycle.
    always_comb begin
        unique case (ld_sel)
            LD_ON_ZERO: load_hit = zero_evt;
            LD_ON_PRD:  load_hit = prd_evt;
            LD_ON_BOTH: load_hit = zero_evt | prd_evt;
            default:    load_hit = 1'b0;
        endcase
    end

    assign hit = cnt_new && (cnt == act);

    // Working/shadow registers and pending flag; write wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= '0;
            shd  <= '0;
            pend <= 1'b0;
        end else if (direct) begin
            if (wr) act <= wdata;
        end else begin
            if (load_hit) begin
                act  <= shd;
                pend <= 1'b0;
            end
            if (wr) begin
                shd  <= wdata;
                pend <= 1'b1;
            end
        end
    end

    // Registered match pulse tagged with the count direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt    <= 1'b0;
            evt_up <= 1'b0;
        end else begin
            evt    <= hit;
            evt_up <= hit && cnt_up;
        end
    end
endmodule

// File: rtl/pwm_cmp_unit.sv
`timescale 1ns/1ps
// Top of the compare-match unit: address decode, control register and
// two compare channels. Match outputs lag the counter by one cycle.
module pwm_cmp_unit
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cnt_new,
    input  logic              cnt_up,
    input  logic              zero_evt,
    input  logic              prd_evt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              cmpa_evt,
    output logic              cmpa_up,
    output logic              cmpb_evt,
    output logic              cmpb_up
);
    logic [CNT_W-1:0] act_w   [NCH];
    logic [CNT_W-1:0] shd_w   [NCH];
    logic             pend_w  [NCH];
    logic             evt_w   [NCH];
    logic             up_w    [NCH];
    logic             dir_w   [NCH];
    ld_sel_e          ld_w    [NCH];
    logic [1:0]       new_ld  [NCH];
    logic             new_dir [NCH];
    logic             ctrl_wr;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADR));

    // Per-channel field slicing and channel instances.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ch_wr;
        assign new_ld[g]  = bus_wdata[LD_LSB + 2*g +: 2];
        assign new_dir[g] = bus_wdata[DIR_LSB + 2*g];
        assign ch_wr      = bus_wr && (bus_addr == ADDR_W'(CMP_BASE + g));

        pwm_cmp_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .direct   (dir_w[g]),
            .ld_sel   (ld_w[g]),
            .wr       (ch_wr),
            .wdata    (bus_wdata),
            .cnt      (cnt),
            .cnt_new  (cnt_new),
            .cnt_up   (cnt_up),
            .zero_evt (zero_evt),
            .prd_evt  (prd_evt),
            .act      (act_w[g]),
            .shd      (shd_w[g]),
            .pend     (pend_w[g]),
            .evt      (evt_w[g]),
            .evt_up   (up_w[g])
        );
    end

    pwm_cmp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .new_ld  (new_ld),
        .new_dir (new_dir),
        .rd_addr (bus_addr),
        .act     (act_w),
        .shd     (shd_w),
        .pend    (pend_w),
        .ld_sel  (ld_w),
        .direct  (dir_w),
        .rdata   (bus_rdata)
    );

    assign cmpa_evt = evt_w[0];
    assign cmpa_up  = up_w[0];
    assign cmpb_evt = evt_w[1];
    assign cmpb_up  = up_w[1];
endmodule

// File: rtl/pwm_cmp_unit_chk.sv
`timescale 1ns/1ps
// Property checker for pwm_cmp_unit, attached by bind below.
module pwm_cmp_unit_chk
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cnt,
    input logic              cnt_new,
    input logic              cnt_up,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic              cmpa_evt,
    input logic              cmpa_up,
    input logic              cmpb_evt,
    input logic              cmpb_up,
    input logic [CNT_W-1:0]  act_a,
    input logic [CNT_W-1:0]  act_b,
    input logic              dir_a,
    input logic [1:0]        ld_a,
    input logic              pend_a
);
    assert_match_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_new && cnt == act_a) |=> (cmpa_evt && cmpa_up == $past(cnt_up)));
    assert_up_needs_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmpa_evt |-> !cmpa_up);
    assert_stall_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_new |=> (!cmpa_evt && !cmpb_evt));
    assert_direct_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_a && bus_wr && bus_addr == ADDR_W'(CMP_BASE)) |=> act_a == $past(bus_wdata));
    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_a && ld_a == 2'b11) |=> $stable(act_a));
    assert_pending_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_a && bus_wr && bus_addr == ADDR_W'(CMP_BASE)) |=> pend_a);
    assert_chan_b_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_new && cnt == act_b) |=> (cmpb_evt && cmpb_up == $past(cnt_up)));
    assert_b_up_needs_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmpb_evt |-> !cmpb_up);
endmodule

bind pwm_cmp_unit pwm_cmp_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt),
    .cnt_new   (cnt_new),
    .cnt_up    (cnt_up),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cmpa_evt  (cmpa_evt),
    .cmpa_up   (cmpa_up),
    .cmpb_evt  (cmpb_evt),
    .cmpb_up   (cmpb_up),
    .act_a     (act_w[0]),
    .act_b     (act_w[1]),
    .dir_a     (dir_w[0]),
    .ld_a      (ld_w[0]),
    .pend_a    (pend_w[0])
);

// File: tb/pwm_cmp_unit_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the step task predicts events from a requirement
// model and queues them; a negedge monitor pops and compares.
module pwm_cmp_unit_test;
    localparam int W   = 16;
    localparam int PRD = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  cnt = '0;
    logic          cnt_new = 1'b0, cnt_up = 1'b1, zero_evt = 1'b0, prd_evt = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic          cmpa_evt, cmpa_up, cmpb_evt, cmpb_up;

    pwm_cmp_unit #(.CNT_W(W)) uut (.*);

    always #2.5 clk = ~clk;

    typedef struct { int stamp; bit up; string tag; } exp_t;
    exp_t q [2][$];

    int  checks = 0, errors = 0, ncnt = 0;
    bit  done = 1'b0;

    // requirement model state
    int m_act [2], m_shd [2], m_ld [2];
    bit m_dir [2], m_pend [2];

    always @(posedge clk) ncnt <= ncnt + 1;

    function automatic int ctrl_exp();
        int v = 0;
        for (int i = 0; i < 2; i++) begin
            v |= m_ld[i] << (2*i);
            v |= int'(m_dir[i]) << (4 + 2*i);
            v |= int'(m_pend[i]) << (8 + i);
        end
        return v;
    endfunction

    task automatic mon(input int ch, input logic e, input logic u);
        while (q[ch].size() > 0 && q[ch][0].stamp < ncnt) begin
            checks++; errors++;
            $display("FAIL %s ch%0d missing event: actual=0 expected=1 (cycle %0d)",
                     q[ch][0].tag, ch, q[ch][0].stamp);
            void'(q[ch].pop_front());
        end
        if (e) begin
            checks++;
            if (q[ch].size() > 0 && q[ch][0].stamp == ncnt) begin
                if (q[ch][0].up != u) begin
                    errors++;
                    $display("FAIL %s ch%0d up flag: actual=%0b expected=%0b",
                             q[ch][0].tag, ch, u, q[ch][0].up);
                end
                void'(q[ch].pop_front());
            end else begin
                errors++;
                $display("FAIL R3/R4 ch%0d unexpected event: actual=1 expected=0 (cycle %0d)", ch, ncnt);
            end
        end
    endtask

    // monitor: sample away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            mon(0, cmpa_evt, cmpa_up);
            mon(1, cmpb_evt, cmpb_up);
        end
    end

    // driver: one cycle of time-base and bus stimulus, with prediction
    task automatic step(input int c, input bit up, input bit nw,
                        input bit wr, input int a, input int d, input string tag);
        bit z, p, hit;
        @(posedge clk); #1;
        z = nw && (c == 0);
        p = nw && (c == PRD);
        cnt = W'(c); cnt_up = up; cnt_new = nw; zero_evt = z; prd_evt = p;
        bus_wr = wr; bus_addr = 2'(a); bus_wdata = W'(d);
        for (int i = 0; i < 2; i++) begin
            if (nw && c == m_act[i]) q[i].push_back('{ncnt + 1, up, tag});
        end
        for (int i = 0; i < 2; i++) begin
            hit = !m_dir[i] && ((m_ld[i] == 0 && z) || (m_ld[i] == 1 && p) ||
                                (m_ld[i] == 2 && (z || p)));
            if (hit) begin m_act[i] = m_shd[i]; m_pend[i] = 1'b0; end
            if (wr && a == 1 + i) begin
                if (m_dir[i]) m_act[i] = d;
                else begin m_shd[i] = d; m_pend[i] = 1'b1; end
            end
        end
        if (wr && a == 0) begin
            m_ld[0] = d & 3;  m_ld[1] = (d >> 2) & 3;
            m_dir[0] = d[4];  m_dir[1] = d[6];
        end
    endtask

    task automatic wr_reg(input int a, input int d, input string tag);
        step(int'(cnt), cnt_up, 1'b0, 1'b1, a, d, tag);
    endtask

    task automatic rd(input int a, input int e, input string tag);
        @(posedge clk); #1;
        cnt_new = 0; zero_evt = 0; prd_evt = 0; bus_wr = 0; bus_addr = 2'(a);
        #1;
        checks++;
        if (bus_rdata !== W'(e)) begin
            errors++;
            $display("FAIL %s read addr %0d: actual=%h expected=%h", tag, a, bus_rdata, W'(e));
        end
    endtask

    task automatic sweep(input int from, input int to, input bit up, input string tag);
        if (up) for (int c = from; c <= to; c++) step(c, 1'b1, 1'b1, 1'b0, 0, 0, tag);
        else    for (int c = from; c >= to; c--) step(c, 1'b0, 1'b1, 1'b0, 0, 0, tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_act[i] = 0; m_shd[i] = 0; m_ld[i] = 0; m_dir[i] = 0; m_pend[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(0, 0, "R1"); rd(1, 0, "R1"); rd(2, 0, "R1");
        rd(0, ctrl_exp(), "R2");

        // direct mode, both channels (R2 R6 R9)
        wr_reg(0, 'h50, "R2");
        wr_reg(1, 5, "R6"); wr_reg(2, 9, "R9");
        rd(0, 'h50, "R2"); rd(1, 5, "R2"); rd(2, 9, "R2");
        sweep(0, PRD, 1'b1, "R3");
        sweep(PRD, 0, 1'b0, "R3");

        // R4 stalled counter at a matching value
        step(5, 1'b1, 1'b1, 1'b0, 0, 0, "R4");
        repeat (3) step(5, 1'b1, 1'b0, 1'b0, 0, 0, "R4");

        // R5 up-down: A inside the range, B at the period, then A at zero
        wr_reg(2, PRD, "R5");
        sweep(0, PRD, 1'b1, "R5"); sweep(PRD - 1, 1, 1'b0, "R5");
        wr_reg(1, 0, "R5");
        sweep(0, PRD, 1'b1, "R5"); sweep(PRD - 1, 1, 1'b0, "R5");

        // R6 write in the same cycle the counter reaches the new value
        wr_reg(1, 5, "R6");
        step(7, 1'b1, 1'b1, 1'b1, 1, 7, "R6");
        step(8, 1'b1, 1'b1, 1'b0, 0, 0, "R6");
        step(7, 1'b0, 1'b1, 1'b0, 0, 0, "R6");
        rd(1, 7, "R6");

        // R7 shadow: A loads on zero, B loads on period
        wr_reg(0, 'h04, "R7");
        wr_reg(1, 3, "R7"); wr_reg(2, 4, "R7");
        rd(1, 3, "R7"); rd(0, ctrl_exp(), "R8");
        sweep(1, PRD, 1'b1, "R7");
        sweep(0, PRD, 1'b1, "R7");
        rd(0, ctrl_exp(), "R8");

        // R7 load on either event for A, frozen B
        wr_reg(0, 'h0E, "R7");
        wr_reg(1, 6, "R7"); wr_reg(2, 8, "R9");
        sweep(0, PRD, 1'b1, "R7"); sweep(PRD - 1, 0, 1'b0, "R7");
        rd(0, ctrl_exp(), "R7");

        // R8 shadow write in the same cycle as the transfer
        wr_reg(0, 'h00, "R8");
        wr_reg(1, 2, "R8");
        step(0, 1'b1, 1'b1, 1'b1, 1, 10, "R8");
        rd(0, ctrl_exp(), "R8"); rd(1, 10, "R8");
        sweep(1, PRD, 1'b1, "R8");
        sweep(0, PRD, 1'b1, "R8");
        rd(0, ctrl_exp(), "R8");

        repeat (4) step(int'(cnt), 1'b1, 1'b0, 1'b0, 0, 0, "R4");
        done = 1'b1;
        for (int i = 0; i < 2; i++) begin
            while (q[i].size() > 0) begin
                checks++; errors++;
                $display("FAIL %s ch%0d missing event at end: actual=0 expected=1",
                         q[i][0].tag, i);
                void'(q[i].pop_front());
            end
        end
        summary();
        $finish;
    end
endmodule